// File: doc/BRIEF.md
# Root Port Status Register

This block holds the single control and status word of a USB host controller's root port. It watches a device-presence level and a reported device speed, records connect and disconnect events, and tracks the port through enable, port reset, suspend and resume. Software reads the whole word on `rdData` and updates it with full-word writes. Writes have per-field rules. Some fields are read-only. Change flags are cleared by writing 1. The enable bit can be turned off by software but never turned on.

The block drives a level interrupt, `portIrq`. It stays high while any change flag or the resume flag is set, so an interrupt handler can service the port and then clear the flags. When software ends a port reset with a device connected, the port enables itself. A remote-wakeup pulse from a suspended device sets the resume flag. Bus signalling on the wire is outside this block.

Top module: `port_ctl_reg`

## Requirements
- R1: The speed field (bits 18:17) and the line-status field (bits 11:10) are read-only. A register write never changes them, and line status always reads 0.
- R2: One cycle after `devPresent` rises, the port reads connected (bit 0 = 1) and connect-detected (bit 1 = 1), and the speed field holds `devSpeed` as sampled (0 = high, 1 = full, 2 = low).
- R3: One cycle after `devPresent` falls, speed, suspend (bit 7), enable (bit 2) and connected (bit 0) read 0, and connect-detected (bit 1) and enable-changed (bit 3) read 1.
- R4: Connect-detected (bit 1), enable-changed (bit 3) and overcurrent-changed (bit 5) clear when written with 1. Writing 0 to them leaves them unchanged.
- R5: Writing 1 to enable (bit 2) disables the port and writing 0 leaves it unchanged. No write can set enable.
- R6: Port reset (bit 8) is read/write. A write that takes it from 1 to 0 while the port reads connected sets enable and enable-changed. With no device connected the same write leaves enable at 0.
- R7: `portIrq` is high exactly while any of bits 1, 3, 5 or 6 of the register is set.
- R8: A `wakeReq` pulse while suspend reads 1 sets resume (bit 6) and so raises `portIrq`. The same pulse has no effect while the port is not suspended.
- R9: A write can set suspend only while enable reads 1. A write that takes resume from 1 to 0 also clears suspend.
- R10: After reset the register reads 0x0000_1000 (power, bit 12, alone). Power is read/write, and bits 4, 9, 13 to 16 and 19 to 31 always read 0.
- R11: When a disconnect and a write fall in the same cycle, the disconnect's effect on its fields takes precedence over the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Current register contents |
| devPresent | input | 1 | Device attached level |
| devSpeed | input | 2 | Speed of the attached device, sampled on attach |
| wakeReq | input | 1 | Remote-wakeup pulse from the device |
| portIrq | output | 1 | Port interrupt level |

## Verification
All results of this block appear on `rdData` and `portIrq` exactly one clock edge after the stimulus: a write strobe, a `devPresent` edge or a `wakeReq` pulse. Both outputs come straight from registers, so the bench changes inputs on the falling clock edge. It then reads the outputs on the next falling edge, after exactly one rising edge. Every scenario checks the full 32-bit word, so a check also shows that fields which should be left alone were not touched. The disconnect-during-write case drives both stimuli in the same cycle so that the precedence rule is observed.

// File: rtl/port_ctl_pkg.sv
package port_ctl_pkg;

  localparam int SPEED_W   = 2;

  // Register bit positions; software decodes these
  localparam int POS_CONN    = 0;
  localparam int POS_CDET    = 1;
  localparam int POS_ENA     = 2;
  localparam int POS_ENACHG  = 3;
  localparam int POS_OVCCHG  = 5;
  localparam int POS_RESUME  = 6;
  localparam int POS_SUSPEND = 7;
  localparam int POS_RESET   = 8;
  localparam int POS_LINE    = 10;
  localparam int POS_POWER   = 12;
  localparam int POS_SPEED   = 17;
  localparam int MIN_REG_W   = POS_SPEED + SPEED_W;

  typedef struct packed {
    logic [SPEED_W-1:0] speed;
    logic               power;
    logic               portReset;
    logic               suspend;
    logic               resume;
    logic               ovcChg;
    logic               enaChg;
    logic               enable;
    logic               connDet;
    logic               connected;
  } portState_t;

  typedef struct packed {
    logic doWrite;
    logic attach;
    logic detach;
    logic wake;
    logic resetDone;
    logic resumeDone;
  } portStrobe_t;

endpackage

// File: rtl/port_ctl_ctrl.sv
module port_ctl_ctrl
  import port_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrReset,
  input  logic        wrResume,
  input  portState_t  cur,
  input  logic        devPresent,
  input  logic        wakeReq,
  output portStrobe_t stb
);

  logic prevPresent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevPresent <= 1'b0;
    else       prevPresent <= devPresent;
  end

  always_comb begin
    stb            = '0;
    stb.doWrite    = wrEn;
    stb.attach     = devPresent && !prevPresent;
    stb.detach     = !devPresent && prevPresent;
    stb.wake       = wakeReq && cur.suspend;
    stb.resetDone  = wrEn && cur.portReset && !wrReset && cur.connected;
    stb.resumeDone = wrEn && cur.resume && !wrResume;
  end

endmodule

// File: rtl/port_ctl_dp.sv
module port_ctl_dp
  import port_ctl_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  portStrobe_t        stb,
  input  logic [REG_W-1:0]   wrData,
  input  logic [SPEED_W-1:0] devSpeed,
  output portState_t         cur,
  output logic [REG_W-1:0]   rdData,
  output logic               portIrq
);

  portState_t nxt;
  logic       unusedWr;

  assign unusedWr = ^wrData;

  always_comb begin
    nxt = cur;
    if (stb.doWrite) begin
      nxt.power     = wrData[POS_POWER];
      nxt.portReset = wrData[POS_RESET];
      nxt.resume    = wrData[POS_RESUME];
      nxt.suspend   = wrData[POS_SUSPEND] && cur.enable;
      nxt.connDet   = cur.connDet && !wrData[POS_CDET];
      nxt.enaChg    = cur.enaChg  && !wrData[POS_ENACHG];
      nxt.ovcChg    = cur.ovcChg  && !wrData[POS_OVCCHG];
      nxt.enable    = cur.enable  && !wrData[POS_ENA];
    end
    if (stb.resumeDone) nxt.suspend = 1'b0;
    if (stb.resetDone) begin
      nxt.enable = 1'b1;
      nxt.enaChg = 1'b1;
    end
    if (stb.wake) nxt.resume = 1'b1;
    if (stb.attach) begin
      nxt.connected = 1'b1;
      nxt.connDet   = 1'b1;
      nxt.speed     = devSpeed;
    end
    if (stb.detach) begin
      nxt.connected = 1'b0;
      nxt.enable    = 1'b0;
      nxt.suspend   = 1'b0;
      nxt.speed     = '0;
      nxt.connDet   = 1'b1;
      nxt.enaChg    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cur       <= '0;
      cur.power <= 1'b1;
      portIrq   <= 1'b0;
    end else begin
      cur     <= nxt;
      portIrq <= nxt.connDet || nxt.enaChg || nxt.ovcChg || nxt.resume;
    end
  end

  always_comb begin
    rdData                             = '0;
    rdData[POS_CONN]                   = cur.connected;
    rdData[POS_CDET]                   = cur.connDet;
    rdData[POS_ENA]                    = cur.enable;
    rdData[POS_ENACHG]                 = cur.enaChg;
    rdData[POS_OVCCHG]                 = cur.ovcChg;
    rdData[POS_RESUME]                 = cur.resume;
    rdData[POS_SUSPEND]                = cur.suspend;
    rdData[POS_RESET]                  = cur.portReset;
    rdData[POS_LINE +: 2]              = 2'b00;
    rdData[POS_POWER]                  = cur.power;
    rdData[POS_SPEED +: SPEED_W]       = cur.speed;
  end

endmodule

// File: rtl/port_ctl_reg.sv
module port_ctl_reg
  import port_ctl_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  input  logic               devPresent,
  input  logic [SPEED_W-1:0] devSpeed,
  input  logic               wakeReq,
  output logic               portIrq
);

  portStrobe_t stb;
  portState_t  cur;

  if (REG_W < MIN_REG_W) begin : g_width_check
    initial $error("REG_W too small for the field layout");
  end

  port_ctl_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrReset    (wrData[POS_RESET]),
    .wrResume   (wrData[POS_RESUME]),
    .cur        (cur),
    .devPresent (devPresent),
    .wakeReq    (wakeReq),
    .stb        (stb)
  );

  port_ctl_dp #(.REG_W(REG_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (wrData),
    .devSpeed (devSpeed),
    .cur      (cur),
    .rdData   (rdData),
    .portIrq  (portIrq)
  );

endmodule

// File: rtl/port_ctl_chk.sv
module port_ctl_chk #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [REG_W-1:0] rdData,
  input logic             devPresent,
  input logic             wakeReq,
  input logic             portIrq
);

  logic prevSeen;
  logic unusedChk;

  assign unusedChk = ^{rdData, wrEn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSeen <= 1'b0;
    else       prevSeen <= devPresent;
  end

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    portIrq == (rdData[1] || rdData[3] || rdData[5] || rdData[6])); // R7

  AST_SPEED_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (devPresent == prevSeen) |=> $stable(rdData[18:17])); // R1

  AST_ATTACH_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (devPresent && !prevSeen) |=> (rdData[0] && rdData[1])); // R2

  AST_DETACH_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (!devPresent && prevSeen) |=> (!rdData[0] && !rdData[2] && !rdData[7]
                                   && rdData[1] && rdData[3])); // R3

  AST_ENABLE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[2]) |-> ($past(rdData[8]) && !rdData[8] && rdData[3])); // R6

  AST_WAKE_RESUME: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReq && rdData[7] && devPresent && prevSeen) |=> (rdData[6] && portIrq)); // R8

endmodule

bind port_ctl_reg port_ctl_chk #(.REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .rdData     (rdData),
  .devPresent (devPresent),
  .wakeReq    (wakeReq),
  .portIrq    (portIrq)
);

// File: tb/port_ctl_reg_tb.sv
module port_ctl_reg_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        devPresent = 1'b0;
  logic [1:0]  devSpeed = 2'd0;
  logic        wakeReq = 1'b0;
  logic        portIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_ctl_reg u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .devPresent(devPresent), .devSpeed(devSpeed), .wakeReq(wakeReq),
    .portIrq(portIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic chkWord(input string req, input logic [31:0] exp, input logic expIrq);
    chk(req, rdData, exp);
    chk({req, " irq"}, {31'd0, portIrq}, {31'd0, expIrq});
  endtask

  task automatic regWrite(input logic [31:0] val);
    wrEn = 1'b1; wrData = val;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic test_reset;
    @(negedge clk);
    chkWord("R10 reset value", 32'h0000_1000, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chkWord("R10 idle after reset", 32'h0000_1000, 1'b0);
  endtask

  task automatic test_attach_full;
    devSpeed = 2'd1; devPresent = 1'b1;
    @(negedge clk);
    chkWord("R2 attach full speed", 32'h0002_1003, 1'b1);
  endtask

  task automatic test_readonly;
    regWrite(32'hFFF8_0000 | 32'h0006_0C00 | 32'h0000_1000);
    chkWord("R1 R10 read-only and reserved", 32'h0002_1003, 1'b1);
  endtask

  task automatic test_w1c;
    regWrite(32'h0000_1002);
    chkWord("R4 clear connect-detected", 32'h0002_1001, 1'b0);
  endtask

  task automatic test_enable_write;
    regWrite(32'h0000_1004);
    chkWord("R5 enable not settable", 32'h0002_1001, 1'b0);
  endtask

  task automatic test_port_reset;
    regWrite(32'h0000_1100);
    chkWord("R6 reset asserted", 32'h0002_1101, 1'b0);
    regWrite(32'h0000_1000);
    chkWord("R6 reset end enables", 32'h0002_100D, 1'b1);
    regWrite(32'h0000_1008);
    chkWord("R4 clear enable-changed", 32'h0002_1005, 1'b0);
  endtask

  task automatic test_suspend_resume;
    regWrite(32'h0000_1080);
    chkWord("R9 suspend while enabled", 32'h0002_1085, 1'b0);
    wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
    chkWord("R8 wake sets resume", 32'h0002_10C5, 1'b1);
    regWrite(32'h0000_1080);
    chkWord("R9 resume end clears suspend", 32'h0002_1005, 1'b0);
    wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
    chkWord("R8 wake ignored when not suspended", 32'h0002_1005, 1'b0);
  endtask

  task automatic test_disable_then_suspend;
    regWrite(32'h0000_1004);
    chkWord("R5 write 1 disables", 32'h0002_1001, 1'b0);
    regWrite(32'h0000_1080);
    chkWord("R9 suspend refused while disabled", 32'h0002_1001, 1'b0);
  endtask

  task automatic test_detach_with_write;
    regWrite(32'h0000_1100);
    regWrite(32'h0000_1000);
    chkWord("R6 re-enable", 32'h0002_100D, 1'b1);
    regWrite(32'h0000_1008);
    regWrite(32'h0000_1080);
    chkWord("R9 suspended again", 32'h0002_1085, 1'b0);
    devPresent = 1'b0;
    regWrite(32'h0000_1100 | 32'h0000_0080);
    chkWord("R3 R11 detach beats write", 32'h0000_110A, 1'b1);
    regWrite(32'h0000_1000);
    chkWord("R6 reset end without device", 32'h0000_100A, 1'b1);
    regWrite(32'h0000_100A);
    chkWord("R4 R7 flags cleared", 32'h0000_1000, 1'b0);
  endtask

  task automatic test_attach_low_power;
    devSpeed = 2'd2; devPresent = 1'b1;
    @(negedge clk);
    chkWord("R2 attach low speed", 32'h0004_1003, 1'b1);
    regWrite(32'h0000_0002);
    chkWord("R10 power cleared", 32'h0004_0001, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_attach_full();
    test_readonly();
    test_w1c();
    test_enable_write();
    test_port_reset();
    test_suspend_resume();
    test_disable_then_suspend();
    test_detach_with_write();
    test_attach_low_power();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule